// File: doc/BRIEF.md
# Dual-Issue In-Order Issue Gate

This block sits between a queue of pre-decoded instructions and the two execution pipes of a statically scheduled core: one integer pipe (which also carries loads, stores and branches) and one floating-point arithmetic pipe. In every cycle it looks at the two oldest queue entries and decides to issue none, the oldest only, or both. It always keeps program order. Each issued record is steered to the pipe its operation class needs.

A pair is split when both entries need the same pipe, when the younger one reads a register the older one writes, or when both write the same register. Before an instruction may issue, a per-register countdown scoreboard must show that every source it reads and the destination it writes have no pending result. The countdown uses fixed latencies: 1 cycle for integer ALU results, 2 for loads and 3 for FP adds. The queue pops entries according to the issue count the block reports.

Record layout, 26 bits from MSB down: op [25:23], dst [22:18], src A [17:13], src B [12:8], tag [7:0]. The op codes are:
- 0 integer ALU: reads int A and int B, writes int dst.
- 1 branch: reads int A and int B.
- 2 integer load: reads int A, writes int dst.
- 3 FP load: reads int A, writes fp dst.
- 4 FP store: reads int A (base) and fp B (data).
- 5 FP add: reads fp A and fp B, writes fp dst.
- 6 and 7: use the integer pipe and have no operands.

Top module: `dual_issue_gate`

## Requirements
- R1: slot1 is accepted only in a cycle where slot0 is also accepted. `issue_cnt` equals the number of accepted entries (0, 1 or 2), and the ready outputs give which entries were taken.
- R2: Op 5 (FP add) is sent on the FP pipe. Every other op is sent on the integer pipe. An issued record appears unchanged on its pipe output, with that pipe's valid high.
- R3: If both oldest entries need the same pipe, only slot0 may issue in that cycle.
- R4: An FP load (op 3) in slot0 whose dst equals an FP source that slot1 reads (A for op 5, B for ops 4 and 5) keeps slot1 back for that cycle. An unrelated FP reader pairs with it.
- R5: An FP add in slot0 followed by an FP store whose data register (src B) is that add's dst keeps the store back for that cycle. A store of a different register pairs with it.
- R6: An integer ALU result can be read by an instruction issued in the very next cycle.
- R7: A load result cannot be read in the cycle after the load issues. It can be read in the second cycle after.
- R8: An FP add result cannot be read in the two cycles after the add issues. It can be read in the third.
- R9: An instruction waits while its own destination has a pending result. Two paired entries that write the same register of the same file are split.
- R10: Synchronous active-low reset clears every pending count and blocks issue while low. After reset, a valid slot0 with any operands issues at once, and with no valid input nothing issues.
- R11: Operand use follows the op table. Op 4 and op 1 write nothing, so their dst field creates no hazard. A register number in one file never blocks a reader of the same number in the other file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot0_valid | input | 1 | Oldest queue entry present |
| slot0_rec | input | 26 | Oldest queue entry record |
| slot0_ready | output | 1 | Oldest entry issued this cycle |
| slot1_valid | input | 1 | Second-oldest queue entry present |
| slot1_rec | input | 26 | Second-oldest queue entry record |
| slot1_ready | output | 1 | Second-oldest entry issued this cycle |
| issue_cnt | output | 2 | Number of entries popped this cycle |
| int_valid | output | 1 | Integer pipe receives a record |
| int_rec | output | 26 | Record sent to the integer pipe |
| fp_valid | output | 1 | FP pipe receives a record |
| fp_rec | output | 26 | Record sent to the FP pipe |

## Verification
The assertions assume that the queue behaves like a queue. The slot1 entry is the one after slot0, and after a pop the entries shift by exactly `issue_cnt`, so the instruction seen in slot0 one or two cycles after an issue is younger than the issued one. The latency checks look back at the pipe outputs and rely on this. The bench keeps to that assumption by holding each program in an array with a head index, presenting entries `head` and `head+1`, and advancing the head by the count the design reports. Random programs draw register numbers from a small range so that dependences, same-register writes and same-class pairs are common.

// File: rtl/issue_pkg.sv
// Shared types and helpers for the dual-issue gate.
// Assumes a 3-bit op code and equal-size integer and FP register files.
package issue_pkg;
    parameter int REG_AW = 5;
    parameter int TAG_W  = 8;
    localparam int NREG  = 1 << REG_AW;

    typedef enum logic [2:0] {
        OP_IALU = 3'd0,
        OP_BR   = 3'd1,
        OP_ILD  = 3'd2,
        OP_FLD  = 3'd3,
        OP_FST  = 3'd4,
        OP_FADD = 3'd5,
        OP_RS6  = 3'd6,
        OP_RS7  = 3'd7
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [REG_AW-1:0] dst;
        logic [REG_AW-1:0] sa;
        logic [REG_AW-1:0] sb;
        logic [TAG_W-1:0]  tag;
    } instr_t;

    localparam int REC_W = $bits(instr_t);

    // Operand use of one op: which register reads and writes it performs.
    typedef struct packed {
        logic rd_ia;
        logic rd_ib;
        logic rd_fa;
        logic rd_fb;
        logic wr_i;
        logic wr_f;
        logic fp_pipe;
    } needs_t;

    // Map an op code to the operands it touches and the pipe it uses.
    function automatic needs_t decode(op_e op);
        needs_t n;
        n = '0;
        case (op)
            OP_IALU: begin n.rd_ia = 1'b1; n.rd_ib = 1'b1; n.wr_i = 1'b1; end
            OP_BR:   begin n.rd_ia = 1'b1; n.rd_ib = 1'b1; end
            OP_ILD:  begin n.rd_ia = 1'b1; n.wr_i = 1'b1; end
            OP_FLD:  begin n.rd_ia = 1'b1; n.wr_f = 1'b1; end
            OP_FST:  begin n.rd_ia = 1'b1; n.rd_fb = 1'b1; end
            OP_FADD: begin n.rd_fa = 1'b1; n.rd_fb = 1'b1; n.wr_f = 1'b1; n.fp_pipe = 1'b1; end
            default: n = '0;
        endcase
        return n;
    endfunction

    // True when the instruction reads FP register r.
    function automatic logic reads_fp(instr_t i, logic [REG_AW-1:0] r);
        needs_t n;
        n = decode(i.op);
        return (n.rd_fa && i.sa == r) || (n.rd_fb && i.sb == r);
    endfunction

    // True when the instruction reads integer register r.
    function automatic logic reads_int(instr_t i, logic [REG_AW-1:0] r);
        needs_t n;
        n = decode(i.op);
        return (n.rd_ia && i.sa == r) || (n.rd_ib && i.sb == r);
    endfunction
endpackage

// File: rtl/reg_scoreboard.sv
// Countdown scoreboard for one register file.
// Each register holds the cycles left before its pending result can be read;
// zero means ready. Two set ports per cycle; port b (younger) wins a clash.
// Assumes set values fit in CW bits.
module reg_scoreboard #(
    parameter int NREG = 32,
    parameter int CW   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wa_en,
    input  logic [$clog2(NREG)-1:0] wa_idx,
    input  logic [CW-1:0]           wa_cnt,
    input  logic                    wb_en,
    input  logic [$clog2(NREG)-1:0] wb_idx,
    input  logic [CW-1:0]           wb_cnt,
    output logic [NREG-1:0]         busy
);
    localparam int AW = $clog2(NREG);

    logic [CW-1:0] cnt [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Load on issue, otherwise count down towards ready.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt[g] <= '0;
            else if (wb_en && wb_idx == AW'(g))
                cnt[g] <= wb_cnt;
            else if (wa_en && wa_idx == AW'(g))
                cnt[g] <= wa_cnt;
            else if (cnt[g] != '0)
                cnt[g] <= cnt[g] - 1'b1;
        end

        // A register is busy while its count is nonzero.
        assign busy[g] = (cnt[g] != '0);
    end
endmodule

// File: rtl/op_decode.sv
// Decodes one queue entry and tests its operands against both scoreboards.
// clear is high when no source it reads and no destination it writes is busy.
module op_decode #(
    parameter int NREG = 32
) (
    input  issue_pkg::op_e             op,
    input  logic [$clog2(NREG)-1:0]    dst,
    input  logic [$clog2(NREG)-1:0]    sa,
    input  logic [$clog2(NREG)-1:0]    sb,
    input  logic [NREG-1:0]            busy_i,
    input  logic [NREG-1:0]            busy_f,
    output issue_pkg::needs_t          nd,
    output logic                       clear
);
    import issue_pkg::*;

    // Operand use and scoreboard readiness for this entry.
    always_comb begin
        nd    = decode(op);
        clear = !(nd.rd_ia && busy_i[sa]) &&
                !(nd.rd_ib && busy_i[sb]) &&
                !(nd.rd_fa && busy_f[sa]) &&
                !(nd.rd_fb && busy_f[sb]) &&
                !(nd.wr_i  && busy_i[dst]) &&
                !(nd.wr_f  && busy_f[dst]);
    end
endmodule

// File: rtl/pair_select.sv
// Issue decision for the two oldest entries.
// slot0 goes when present and clear. slot1 goes only with slot0, on the other
// pipe, clear, and with no read-after-write or same-destination clash
// against slot0. Nothing issues while reset is low.
module pair_select #(
    parameter int AW = 5
) (
    input  logic              rst_n,
    input  logic              v0,
    input  logic              v1,
    input  logic              clear0,
    input  logic              clear1,
    input  logic              fp0,
    input  logic              wr_i0,
    input  logic              wr_f0,
    input  logic [AW-1:0]     dst0,
    input  issue_pkg::needs_t nd1,
    input  logic [AW-1:0]     sa1,
    input  logic [AW-1:0]     sb1,
    input  logic [AW-1:0]     dst1,
    output logic              go0,
    output logic              go1
);
    logic raw;
    logic waw;

    // Hazards inside the packet, then the two issue decisions.
    always_comb begin
        raw = (wr_f0 && ((nd1.rd_fa && sa1 == dst0) || (nd1.rd_fb && sb1 == dst0))) ||
              (wr_i0 && ((nd1.rd_ia && sa1 == dst0) || (nd1.rd_ib && sb1 == dst0)));
        waw = (dst1 == dst0) && ((wr_i0 && nd1.wr_i) || (wr_f0 && nd1.wr_f));
        go0 = rst_n && v0 && clear0;
        go1 = go0 && v1 && clear1 && (fp0 != nd1.fp_pipe) && !raw && !waw;
    end
endmodule

// File: rtl/dual_issue_gate.sv
// Dual-issue in-order gate: picks 0, 1 or 2 of the two oldest entries,
// routes them to the integer and FP pipes and tracks result latencies.
// Assumes the queue pops exactly issue_cnt entries each cycle.
module dual_issue_gate
    import issue_pkg::*;
#(
    parameter int LAT_INT  = 1,
    parameter int LAT_LOAD = 2,
    parameter int LAT_FP   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot0_valid,
    input  logic [REC_W-1:0] slot0_rec,
    output logic             slot0_ready,
    input  logic             slot1_valid,
    input  logic [REC_W-1:0] slot1_rec,
    output logic             slot1_ready,
    output logic [1:0]       issue_cnt,
    output logic             int_valid,
    output logic [REC_W-1:0] int_rec,
    output logic             fp_valid,
    output logic [REC_W-1:0] fp_rec
);
    localparam int MAX_LAT = (LAT_FP > LAT_LOAD) ?
                             ((LAT_FP > LAT_INT) ? LAT_FP : LAT_INT) :
                             ((LAT_LOAD > LAT_INT) ? LAT_LOAD : LAT_INT);
    localparam int CW = $clog2(MAX_LAT + 1);

    instr_t            rec [2];
    needs_t            nd  [2];
    logic              clr [2];
    logic [NREG-1:0]   busy_i;
    logic [NREG-1:0]   busy_f;
    logic              go0;
    logic              go1;

    // Count loaded into the scoreboard when an op issues.
    function automatic logic [CW-1:0] hold_of(op_e op);
        case (op)
            OP_ILD, OP_FLD: return CW'(LAT_LOAD - 1);
            OP_FADD:        return CW'(LAT_FP - 1);
            default:        return CW'(LAT_INT - 1);
        endcase
    endfunction

    assign rec[0] = instr_t'(slot0_rec);
    assign rec[1] = instr_t'(slot1_rec);

    for (genvar s = 0; s < 2; s++) begin : g_slot
        op_decode #(.NREG(NREG)) u_dec (
            .op     (rec[s].op),
            .dst    (rec[s].dst),
            .sa     (rec[s].sa),
            .sb     (rec[s].sb),
            .busy_i (busy_i),
            .busy_f (busy_f),
            .nd     (nd[s]),
            .clear  (clr[s])
        );
    end

    pair_select #(.AW(REG_AW)) u_sel (
        .rst_n  (rst_n),
        .v0     (slot0_valid),
        .v1     (slot1_valid),
        .clear0 (clr[0]),
        .clear1 (clr[1]),
        .fp0    (nd[0].fp_pipe),
        .wr_i0  (nd[0].wr_i),
        .wr_f0  (nd[0].wr_f),
        .dst0   (rec[0].dst),
        .nd1    (nd[1]),
        .sa1    (rec[1].sa),
        .sb1    (rec[1].sb),
        .dst1   (rec[1].dst),
        .go0    (go0),
        .go1    (go1)
    );

    reg_scoreboard #(.NREG(NREG), .CW(CW)) u_sb_int (
        .clk    (clk),
        .rst_n  (rst_n),
        .wa_en  (go0 && nd[0].wr_i),
        .wa_idx (rec[0].dst),
        .wa_cnt (hold_of(rec[0].op)),
        .wb_en  (go1 && nd[1].wr_i),
        .wb_idx (rec[1].dst),
        .wb_cnt (hold_of(rec[1].op)),
        .busy   (busy_i)
    );

    reg_scoreboard #(.NREG(NREG), .CW(CW)) u_sb_fp (
        .clk    (clk),
        .rst_n  (rst_n),
        .wa_en  (go0 && nd[0].wr_f),
        .wa_idx (rec[0].dst),
        .wa_cnt (hold_of(rec[0].op)),
        .wb_en  (go1 && nd[1].wr_f),
        .wb_idx (rec[1].dst),
        .wb_cnt (hold_of(rec[1].op)),
        .busy   (busy_f)
    );

    // Pop count, handshakes and steering of issued records to the pipes.
    always_comb begin
        slot0_ready = go0;
        slot1_ready = go1;
        issue_cnt   = {go0 && go1, go0 ^ go1};
        int_valid   = (go0 && !nd[0].fp_pipe) || (go1 && !nd[1].fp_pipe);
        fp_valid    = (go0 && nd[0].fp_pipe) || (go1 && nd[1].fp_pipe);
        int_rec     = (go0 && !nd[0].fp_pipe) ? slot0_rec : slot1_rec;
        fp_rec      = (go0 && nd[0].fp_pipe) ? slot0_rec : slot1_rec;
    end
endmodule

// File: rtl/issue_gate_chk.sv
// Port-level checker for dual_issue_gate, attached by bind.
// Assumes the queue shifts by issue_cnt, so slot0 after an issue is younger.
module issue_gate_chk
    import issue_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             slot0_valid,
    input logic [REC_W-1:0] slot0_rec,
    input logic             slot0_ready,
    input logic             slot1_valid,
    input logic [REC_W-1:0] slot1_rec,
    input logic             slot1_ready,
    input logic [1:0]       issue_cnt,
    input logic             int_valid,
    input logic [REC_W-1:0] int_rec,
    input logic             fp_valid,
    input logic [REC_W-1:0] fp_rec
);
    instr_t c0, c1, ci, cf;
    assign c0 = instr_t'(slot0_rec);
    assign c1 = instr_t'(slot1_rec);
    assign ci = instr_t'(int_rec);
    assign cf = instr_t'(fp_rec);

    a_r1_younger_needs_older: assert property (@(posedge clk) disable iff (!rst_n)
        slot1_ready |-> slot0_ready);
    a_r1_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
        issue_cnt == 2'(slot0_ready) + 2'(slot1_ready));
    a_r1_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (slot0_ready |-> slot0_valid) and (slot1_ready |-> slot1_valid));
    a_r2_fp_pipe_op: assert property (@(posedge clk) disable iff (!rst_n)
        fp_valid |-> cf.op == OP_FADD);
    a_r2_int_pipe_op: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid |-> ci.op != OP_FADD);
    a_r2_pipes_match_count: assert property (@(posedge clk) disable iff (!rst_n)
        issue_cnt == 2'(int_valid) + 2'(fp_valid));
    a_r2_int_rec_pass: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid |-> (int_rec == slot0_rec || int_rec == slot1_rec));
    a_r3_same_class_split: assert property (@(posedge clk) disable iff (!rst_n)
        ((c0.op == OP_FADD) == (c1.op == OP_FADD)) |-> !slot1_ready);
    a_r4_load_use_split: assert property (@(posedge clk) disable iff (!rst_n)
        (c0.op == OP_FLD && reads_fp(c1, c0.dst)) |-> !slot1_ready);
    a_r5_store_split: assert property (@(posedge clk) disable iff (!rst_n)
        (c0.op == OP_FADD && c1.op == OP_FST && c1.sb == c0.dst) |-> !slot1_ready);
    a_r7_int_load_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(int_valid) && $past(ci.op) == OP_ILD && reads_int(c0, $past(ci.dst)))
        |-> !slot0_ready);
    a_r7_fp_load_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(int_valid) && $past(ci.op) == OP_FLD && reads_fp(c0, $past(ci.dst)))
        |-> !slot0_ready);
    a_r8_fadd_gap1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fp_valid) && reads_fp(c0, $past(cf.dst))) |-> !slot0_ready);
    a_r8_fadd_gap2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fp_valid, 2) && reads_fp(c0, $past(cf.dst, 2))) |-> !slot0_ready);
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !slot0_valid |-> (issue_cnt == 2'd0 && !int_valid && !fp_valid));
endmodule

bind dual_issue_gate issue_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot0_valid (slot0_valid),
    .slot0_rec   (slot0_rec),
    .slot0_ready (slot0_ready),
    .slot1_valid (slot1_valid),
    .slot1_rec   (slot1_rec),
    .slot1_ready (slot1_ready),
    .issue_cnt   (issue_cnt),
    .int_valid   (int_valid),
    .int_rec     (int_rec),
    .fp_valid    (fp_valid),
    .fp_rec      (fp_rec)
);

// File: tb/sim_dual_issue_gate.sv
module sim_dual_issue_gate;
    import issue_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LI = 1;
    localparam int LL = 2;
    localparam int LF = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             slot0_valid, slot1_valid;
    logic [REC_W-1:0] slot0_rec, slot1_rec;
    logic             slot0_ready, slot1_ready;
    logic [1:0]       issue_cnt;
    logic             int_valid, fp_valid;
    logic [REC_W-1:0] int_rec, fp_rec;

    dual_issue_gate u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int     n_chk = 0;
    int     n_bad = 0;
    int     mi [NREG];
    int     mf [NREG];
    instr_t prog [64];
    int     icyc [64];
    int     plen, head, cyc;

    // Requirement-level op table, kept separate from the design.
    function automatic bit b_fp(op_e o);  return o == OP_FADD; endfunction
    function automatic bit b_ria(op_e o); return o inside {OP_IALU, OP_BR, OP_ILD, OP_FLD, OP_FST}; endfunction
    function automatic bit b_rib(op_e o); return o inside {OP_IALU, OP_BR}; endfunction
    function automatic bit b_rfa(op_e o); return o == OP_FADD; endfunction
    function automatic bit b_rfb(op_e o); return o inside {OP_FST, OP_FADD}; endfunction
    function automatic bit b_wi(op_e o);  return o inside {OP_IALU, OP_ILD}; endfunction
    function automatic bit b_wf(op_e o);  return o inside {OP_FLD, OP_FADD}; endfunction
    function automatic int b_lat(op_e o);
        if (o inside {OP_ILD, OP_FLD}) return LL;
        if (o == OP_FADD) return LF;
        return LI;
    endfunction

    function automatic instr_t mk(op_e o, int d, int a, int b, int t);
        instr_t r;
        r.op = o; r.dst = REG_AW'(d); r.sa = REG_AW'(a); r.sb = REG_AW'(b); r.tag = TAG_W'(t);
        return r;
    endfunction

    // An entry is ready when no source it reads or dst it writes is pending.
    function automatic bit b_ready(instr_t r);
        if (b_ria(r.op) && mi[r.sa] != 0) return 0;
        if (b_rib(r.op) && mi[r.sb] != 0) return 0;
        if (b_rfa(r.op) && mf[r.sa] != 0) return 0;
        if (b_rfb(r.op) && mf[r.sb] != 0) return 0;
        if (b_wi(r.op)  && mi[r.dst] != 0) return 0;
        if (b_wf(r.op)  && mf[r.dst] != 0) return 0;
        return 1;
    endfunction

    function automatic bit b_pair(instr_t p, instr_t q);
        bit raw, waw;
        raw = (b_wf(p.op) && ((b_rfa(q.op) && q.sa == p.dst) || (b_rfb(q.op) && q.sb == p.dst))) ||
              (b_wi(p.op) && ((b_ria(q.op) && q.sa == p.dst) || (b_rib(q.op) && q.sb == p.dst)));
        waw = (q.dst == p.dst) && ((b_wi(p.op) && b_wi(q.op)) || (b_wf(p.op) && b_wf(q.op)));
        return (b_fp(p.op) != b_fp(q.op)) && !raw && !waw;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: present head entries, compare the decision, advance.
    task automatic step();
        bit e0, e1, ei, ef, g0, g1;
        instr_t p0, p1;
        @(negedge clk);
        slot0_valid = (head < plen);
        slot1_valid = (head + 1 < plen);
        p0 = slot0_valid ? prog[head] : '0;
        p1 = slot1_valid ? prog[head + 1] : '0;
        slot0_rec = p0;
        slot1_rec = p1;
        #1;
        e0 = slot0_valid && b_ready(p0);
        e1 = e0 && slot1_valid && b_ready(p1) && b_pair(p0, p1);
        ei = (e0 && !b_fp(p0.op)) || (e1 && !b_fp(p1.op));
        ef = (e0 && b_fp(p0.op)) || (e1 && b_fp(p1.op));
        check(issue_cnt == 2'(e0) + 2'(e1) && slot0_ready == e0 && slot1_ready == e1,
              "R1", "issue count/readies", {issue_cnt, slot0_ready, slot1_ready},
              {2'(e0) + 2'(e1), e0, e1});
        check(int_valid == ei && fp_valid == ef &&
              (!ei || int_rec == ((e0 && !b_fp(p0.op)) ? p0 : p1)) &&
              (!ef || fp_rec == ((e0 && b_fp(p0.op)) ? p0 : p1)),
              "R2", "pipe routing", {int_valid, fp_valid}, {ei, ef});
        g0 = slot0_ready;
        g1 = slot1_ready;
        if (g0) icyc[head] = cyc;
        if (g1) icyc[head + 1] = cyc;
        @(posedge clk);
        for (int k = 0; k < NREG; k++) begin
            if (mi[k] > 0) mi[k]--;
            if (mf[k] > 0) mf[k]--;
        end
        if (g0 && b_wi(p0.op)) mi[p0.dst] = b_lat(p0.op) - 1;
        if (g0 && b_wf(p0.op)) mf[p0.dst] = b_lat(p0.op) - 1;
        if (g1 && b_wi(p1.op)) mi[p1.dst] = b_lat(p1.op) - 1;
        if (g1 && b_wf(p1.op)) mf[p1.dst] = b_lat(p1.op) - 1;
        head += 32'(g0) + 32'(g1);
        cyc++;
    endtask

    task automatic run(int n);
        int guard;
        plen = n; head = 0; guard = 0;
        for (int k = 0; k < 64; k++) icyc[k] = -1;
        while (head < plen && guard < 300) begin step(); guard++; end
        for (int k = 0; k < 4; k++) step();
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; cyc = 0; plen = 0; head = 0;
        for (int k = 0; k < NREG; k++) begin mi[k] = 0; mf[k] = 0; end
        slot0_valid = 1'b1; slot0_rec = mk(OP_IALU, 1, 2, 3, 0);
        slot1_valid = 1'b1; slot1_rec = mk(OP_FADD, 1, 2, 3, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(issue_cnt == 0 && !int_valid && !fp_valid, "R10", "no issue in reset",
              {issue_cnt, int_valid, fp_valid}, 0);
        rst_n = 1'b1;
        slot0_valid = 1'b0; slot1_valid = 1'b0;
        #1;
        check(issue_cnt == 0 && !int_valid && !fp_valid, "R10", "idle after reset",
              {issue_cnt, int_valid, fp_valid}, 0);

        // R10: first instruction after reset issues at once.
        prog[0] = mk(OP_FADD, 1, 2, 3, 1);
        begin int c0; c0 = cyc; run(1); check(icyc[0] == c0, "R10", "first issue cycle", icyc[0], c0); end
        // R2: int + fp pair goes together.
        prog[0] = mk(OP_IALU, 1, 2, 3, 2); prog[1] = mk(OP_FADD, 4, 5, 6, 3);
        run(2); check(icyc[1] == icyc[0], "R2", "mixed pair", icyc[1] - icyc[0], 0);
        // R3: same class splits.
        prog[0] = mk(OP_IALU, 1, 2, 3, 4); prog[1] = mk(OP_BR, 0, 5, 6, 5);
        run(2); check(icyc[1] - icyc[0] == 1, "R3", "int pair split", icyc[1] - icyc[0], 1);
        prog[0] = mk(OP_FADD, 1, 2, 3, 6); prog[1] = mk(OP_FADD, 4, 5, 6, 7);
        run(2); check(icyc[1] - icyc[0] == 1, "R3", "fp pair split", icyc[1] - icyc[0], 1);
        // R4 and R7: fp load feeding fp add.
        prog[0] = mk(OP_FLD, 4, 1, 0, 8); prog[1] = mk(OP_FADD, 5, 4, 6, 9);
        run(2); check(icyc[1] - icyc[0] == 2, "R4", "load-use split", icyc[1] - icyc[0], 2);
        prog[0] = mk(OP_FLD, 4, 1, 0, 10); prog[1] = mk(OP_FADD, 5, 7, 6, 11);
        run(2); check(icyc[1] == icyc[0], "R4", "unrelated reader pairs", icyc[1] - icyc[0], 0);
        // R5: fp add feeding fp store data.
        prog[0] = mk(OP_FADD, 8, 1, 2, 12); prog[1] = mk(OP_FST, 0, 1, 8, 13);
        run(2); check(icyc[1] - icyc[0] == 3, "R5", "store split", icyc[1] - icyc[0], 3);
        prog[0] = mk(OP_FADD, 8, 1, 2, 14); prog[1] = mk(OP_FST, 0, 1, 9, 15);
        run(2); check(icyc[1] == icyc[0], "R5", "other store pairs", icyc[1] - icyc[0], 0);
        // R6: integer result used next cycle.
        prog[0] = mk(OP_IALU, 2, 0, 1, 16); prog[1] = mk(OP_FADD, 1, 2, 3, 17);
        prog[2] = mk(OP_IALU, 3, 2, 2, 18);
        run(3); check(icyc[2] - icyc[0] == 1, "R6", "int latency", icyc[2] - icyc[0], 1);
        // R7: integer load latency.
        prog[0] = mk(OP_ILD, 5, 1, 0, 19); prog[1] = mk(OP_BR, 0, 5, 5, 20);
        run(2); check(icyc[1] - icyc[0] == 2, "R7", "load latency", icyc[1] - icyc[0], 2);
        // R8: fp add latency.
        prog[0] = mk(OP_FADD, 9, 1, 2, 21); prog[1] = mk(OP_FADD, 10, 9, 1, 22);
        run(2); check(icyc[1] - icyc[0] == 3, "R8", "fadd latency", icyc[1] - icyc[0], 3);
        // R9: same fp destination in a pair.
        prog[0] = mk(OP_FADD, 11, 1, 2, 23); prog[1] = mk(OP_FLD, 11, 1, 0, 24);
        run(2); check(icyc[1] - icyc[0] == 3, "R9", "dst pending", icyc[1] - icyc[0], 3);
        // R11: store writes nothing; files are separate.
        prog[0] = mk(OP_FST, 7, 1, 2, 25); prog[1] = mk(OP_FADD, 12, 7, 7, 26);
        run(2); check(icyc[1] == icyc[0], "R11", "store dst ignored", icyc[1] - icyc[0], 0);
        prog[0] = mk(OP_FADD, 1, 2, 3, 27); prog[1] = mk(OP_IALU, 4, 1, 1, 28);
        run(2); check(icyc[1] == icyc[0], "R11", "file separation", icyc[1] - icyc[0], 0);

        // Random programs with dense register reuse.
        for (int t = 0; t < 250; t++) begin
            for (int k = 0; k < 40; k++)
                prog[k] = mk(op_e'($urandom % 8), $urandom % 4, $urandom % 4, $urandom % 4, k);
            run(40);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule